// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product with a single N-bit adder that is reused over N iterations. Four registers form the datapath: a one-bit carry flag, an N-bit accumulator, an N-bit multiplier shift register and an N-bit multiplicand holding register. The carry, accumulator and multiplier registers form one right-shifting chain. When the work is finished, the accumulator holds the upper half of the product and the multiplier register holds the lower half.

A four-state controller runs the datapath: idle, add, shift and done. An iteration counter counts the add/shift pairs. Each multiplier bit takes one add cycle and one shift cycle, so a product is ready 2N cycles after the start is accepted. The result stays on the output, with a done flag, until a later start request returns the block to idle.

A caller pulses `start_i` while the block is idle, with both operands on the inputs. It waits for `done_o` and reads `product_o`. It pulses `start_i` once more to release the block. A further start pulse in idle then begins the next multiply.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst_n` is low, and until the first start after it, `done_o` is 0 and `product_o` is all zeros. Asserting `rst_n` low in the middle of a multiply stops it and returns the controller to idle.
- R2: When `start_i` is high at a clock edge in idle, that edge clears the carry and the accumulator, captures `mcand_i` as the multiplicand and `mplier_i` as the multiplier, zeroes the iteration counter and moves to the add state.
- R3: In the add state, {carry, accumulator} becomes accumulator + multiplicand when bit 0 of the multiplier register is 1, and accumulator + 0 when it is 0. The multiplier and multiplicand registers keep their values.
- R4: In the shift state, {carry, accumulator, multiplier} shifts right by one bit with a 0 entering the carry. The iteration counter then advances by one, or the controller moves to done after the N-th shift.
- R5: Exactly N add/shift pairs run, so `done_o` first reads 1 in the cycle that follows the 2N-th clock edge after the start edge.
- R6: In done, `product_o` (upper half from the accumulator, lower half from the multiplier register) equals the unsigned product of the captured operands. For N=4, 1010 x 1011 gives 01101110 and 1101 x 0101 gives 01000001.
- R7: In done, `done_o` stays 1 and `product_o` stays stable whatever the operand inputs do. A start there moves to idle without touching any register, so the product remains visible in idle until the next start.
- R8: Changes of `start_i`, `mcand_i` and `mplier_i` while a multiply is in the add or shift states have no effect on the run or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request in idle, release request in done |
| mcand_i | input | N | Multiplicand operand |
| mplier_i | input | N | Multiplier operand |
| done_o | output | 1 | High while the finished product is held |
| product_o | output | 2N | Product: accumulator above, multiplier register below |

## Verification
On every cycle the assertions check the load that clears the carry and accumulator, the conditional sum of the add step, the one-bit right shift of the carry-accumulator-multiplier chain, counter stepping, the entry into done after the last shift, and that the multiplicand holds steady during a run and the product holds steady in done. Only the bench's scenarios can show that the right product comes out of the whole sequence. These scenarios are every 4-bit operand pair, the two worked 4-bit cases, random and extreme 8-bit pairs, start pulses and operand noise during a run and in done, and a reset that cuts off a multiply.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } mul_state_e;

endpackage

// File: rtl/shift_add_mult_rst_sync.sv
module shift_add_mult_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/shift_add_mult_adder.sv
module shift_add_mult_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);

  logic [N:0] carry;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic half;
    assign half         = a_i[g] ^ b_i[g];
    assign sum_o[g]     = half ^ carry[g];
    assign carry[g+1]   = (a_i[g] & b_i[g]) | (carry[g] & half);
  end

  assign cout_o = carry[N];

endmodule

// File: rtl/shift_add_mult_ctrl.sv
module shift_add_mult_ctrl
  import shift_add_mult_pkg::*;
#(
  parameter int N = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output mul_state_e    state_o,
  output logic [CW-1:0] cnt_o,
  output logic          load_en_o,
  output logic          add_en_o,
  output logic          shift_en_o,
  output logic          done_o
);

  localparam logic [CW-1:0] LAST = CW'(N - 1);

  mul_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          last_iter;

  assign last_iter = (cnt_q == LAST);

  // next-state and control decode
  always_comb begin
    state_d    = state_q;
    load_en_o  = 1'b0;
    add_en_o   = 1'b0;
    shift_en_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_en_o = 1'b1;
          state_d   = ST_ADD;
        end
      end
      ST_ADD: begin
        add_en_o = 1'b1;
        state_d  = ST_SHIFT;
      end
      ST_SHIFT: begin
        shift_en_o = 1'b1;
        state_d    = last_iter ? ST_DONE : ST_ADD;
      end
      ST_DONE: begin
        if (start_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // iteration counter next value
  always_comb begin
    cnt_en = load_en_o | shift_en_o;
    cnt_d  = cnt_q;
    if (load_en_o) begin
      cnt_d = '0;
    end else if (shift_en_o) begin
      cnt_d = last_iter ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign done_o  = (state_q == ST_DONE);

endmodule

// File: rtl/shift_add_mult_dp.sv
module shift_add_mult_dp #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en_i,
  input  logic         add_en_i,
  input  logic         shift_en_i,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic         cy_o,
  output logic [N-1:0] acc_o,
  output logic [N-1:0] mq_o,
  output logic [N-1:0] mc_o
);

  logic         cy_q, cy_d;
  logic [N-1:0] acc_q, acc_d;
  logic [N-1:0] mq_q, mq_d;
  logic [N-1:0] mc_q;
  logic [N-1:0] pp;
  logic [N-1:0] sum;
  logic         sum_cout;
  logic         chain_en;

  // partial product: multiplicand or zero
  assign pp = mq_q[0] ? mc_q : '0;

  shift_add_mult_adder #(.N(N)) u_adder (
    .a_i    (acc_q),
    .b_i    (pp),
    .cin_i  (1'b0),
    .sum_o  (sum),
    .cout_o (sum_cout)
  );

  assign chain_en = load_en_i | add_en_i | shift_en_i;

  always_comb begin
    cy_d  = cy_q;
    acc_d = acc_q;
    mq_d  = mq_q;
    if (load_en_i) begin
      cy_d  = 1'b0;
      acc_d = '0;
      mq_d  = mplier_i;
    end else if (add_en_i) begin
      cy_d  = sum_cout;
      acc_d = sum;
    end else if (shift_en_i) begin
      cy_d  = 1'b0;
      acc_d = {cy_q, acc_q[N-1:1]};
      mq_d  = {acc_q[0], mq_q[N-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q  <= 1'b0;
      acc_q <= '0;
      mq_q  <= '0;
    end else if (chain_en) begin
      cy_q  <= cy_d;
      acc_q <= acc_d;
      mq_q  <= mq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q <= '0;
    end else if (load_en_i) begin
      mc_q <= mcand_i;
    end
  end

  assign cy_o  = cy_q;
  assign acc_o = acc_q;
  assign mq_o  = mq_q;
  assign mc_o  = mc_q;

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import shift_add_mult_pkg::*;
#(
  parameter int N = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic           done_o,
  output logic [2*N-1:0] product_o
);

  logic          rst_int_n;
  mul_state_e    state;
  logic [CW-1:0] cnt;
  logic          load_en;
  logic          add_en;
  logic          shift_en;
  logic          cy;
  logic [N-1:0]  acc;
  logic [N-1:0]  mq;
  logic [N-1:0]  mc;

  shift_add_mult_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  shift_add_mult_ctrl #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .state_o    (state),
    .cnt_o      (cnt),
    .load_en_o  (load_en),
    .add_en_o   (add_en),
    .shift_en_o (shift_en),
    .done_o     (done_o)
  );

  shift_add_mult_dp #(.N(N)) u_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_en_i  (load_en),
    .add_en_i   (add_en),
    .shift_en_i (shift_en),
    .mcand_i    (mcand_i),
    .mplier_i   (mplier_i),
    .cy_o       (cy),
    .acc_o      (acc),
    .mq_o       (mq),
    .mc_o       (mc)
  );

  assign product_o = {acc, mq};

endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk
  import shift_add_mult_pkg::*;
#(
  parameter int N = 8,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic [N-1:0]   mcand_i,
  input logic [N-1:0]   mplier_i,
  input mul_state_e     state,
  input logic [CW-1:0]  cnt,
  input logic           cy,
  input logic [N-1:0]   acc,
  input logic [N-1:0]   mq,
  input logic [N-1:0]   mc,
  input logic           done_o,
  input logic [2*N-1:0] product_o
);

  localparam logic [CW-1:0] LAST = CW'(N - 1);

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_i) |=> (state == ST_ADD && cy == 1'b0 && acc == '0
      && cnt == '0 && mq == $past(mplier_i) && mc == $past(mcand_i))); // R2

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADD) |=> ({cy, acc} == ({1'b0, $past(acc)}
      + {1'b0, ($past(mq[0]) ? $past(mc) : {N{1'b0}})}) && $stable(mq))); // R3

  AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT) |=> ({cy, acc, mq} == {1'b0, $past(cy), $past(acc), $past(mq[N-1:1])})); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && cnt != LAST) |=> (state == ST_ADD && cnt == $past(cnt) + 1'b1)); // R4

  AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(state) == ST_SHIFT && $past(cnt) == LAST)); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> $stable(product_o)); // R7

  AST_BUSY_MC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADD || state == ST_SHIFT) |=> $stable(mc)); // R8

endmodule

bind shift_add_mult shift_add_mult_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .start_i   (start_i),
  .mcand_i   (mcand_i),
  .mplier_i  (mplier_i),
  .state     (state),
  .cnt       (cnt),
  .cy        (cy),
  .acc       (acc),
  .mq        (mq),
  .mc        (mc),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/shift_add_mult_tb.sv
`timescale 1ns/1ps
module shift_add_mult_tb;

  localparam int N = 8;

  logic           clk;
  logic           rst_n;
  logic           start_i;
  logic [N-1:0]   mcand_i;
  logic [N-1:0]   mplier_i;
  logic           done_o;
  logic [2*N-1:0] product_o;

  int n_cmp  = 0;
  int n_bad  = 0;
  int cycles = 0;

  shift_add_mult #(.N(N)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .done_o    (done_o),
    .product_o (product_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference: 0 idle, 1 add, 2 shift, 3 done
  int             m_state;
  int             m_iter;
  logic [2*N-1:0] m_prod;
  bit             m_known;
  logic [N-1:0]   m_a, m_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_iter = 0; m_prod = '0; m_known = 1'b1;
    end else begin
      case (m_state)
        0: if (start_i) begin
             m_a = mcand_i; m_b = mplier_i; m_iter = 0; m_known = 1'b0; m_state = 1;
           end
        1: m_state = 2;
        2: begin
             m_iter++;
             if (m_iter == N) begin
               m_state = 3;
               m_prod  = (2*N)'(m_a) * (2*N)'(m_b);
               m_known = 1'b1;
             end else begin
               m_state = 1;
             end
           end
        default: if (start_i) m_state = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [2*N-1:0] act,
                       input logic [2*N-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(done_o === (m_state == 3), "R5 R7 done flag", {{(2*N-1){1'b0}}, done_o},
            {{(2*N-1){1'b0}}, (m_state == 3)});
      if (m_known)
        check(product_o === m_prod, "R3 R4 R6 product", product_o, m_prod);
    end
  end

  initial begin
    wait (cycles > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b, input bit poke);
    @(negedge clk); start_i = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk); start_i = 1'b0; mcand_i = ~a; mplier_i = b ^ 8'h5A;
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; mcand_i = $urandom; mplier_i = $urandom;   // R8 busy start
      @(negedge clk); start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    check(product_o === (2*N)'(a) * (2*N)'(b), "R6 final", product_o, (2*N)'(a) * (2*N)'(b));
    if (poke)
      check(product_o === (2*N)'(a) * (2*N)'(b), "R8 busy start ignored", product_o,
            (2*N)'(a) * (2*N)'(b));
    repeat (2) begin
      @(negedge clk); mcand_i = $urandom; mplier_i = $urandom;  // R7 noise in done
    end
    check(done_o === 1'b1, "R7 done held", {15'd0, done_o}, 16'd1);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(done_o === 1'b0 && product_o === (2*N)'(a) * (2*N)'(b), "R7 release keeps product",
          product_o, (2*N)'(a) * (2*N)'(b));
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mcand_i = '0; mplier_i = '0;
    repeat (3) @(negedge clk);
    check(done_o === 1'b0 && product_o === '0, "R1 in reset", product_o, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done_o === 1'b0 && product_o === '0, "R1 after reset", product_o, '0);

    // R6 worked 4-bit cases
    run_mul(8'b0000_1010, 8'b0000_1011, 1'b0);
    check(product_o[7:0] === 8'b0110_1110, "R6 1010x1011", product_o, 16'h006E);
    run_mul(8'b0000_1101, 8'b0000_0101, 1'b0);
    check(product_o[7:0] === 8'b0100_0001, "R6 1101x0101", product_o, 16'h0041);

    // R2 first cycle after a start: not done, still loading
    @(negedge clk); start_i = 1'b1; mcand_i = 8'd3; mplier_i = 8'd7;
    @(negedge clk); start_i = 1'b0;
    check(done_o === 1'b0, "R2 start accepted, busy", {15'd0, done_o}, 16'd0);
    while (!done_o) @(negedge clk);
    check(product_o === 16'd21, "R2 R6 3x7", product_o, 16'd21);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;

    // exhaustive 4-bit operands
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_mul(N'(i), N'(j), ((i + j) % 5) == 0);

    // extreme 8-bit operands
    run_mul(8'hFF, 8'hFF, 1'b1);
    run_mul(8'hFF, 8'h00, 1'b0);
    run_mul(8'h80, 8'h01, 1'b0);
    run_mul(8'h01, 8'h80, 1'b1);

    // random 8-bit operands
    for (int k = 0; k < 200; k++)
      run_mul(N'($urandom), N'($urandom), (k % 3) == 0);

    // R1 reset in the middle of a run
    @(negedge clk); start_i = 1'b1; mcand_i = 8'hC3; mplier_i = 8'h9D;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(done_o === 1'b0 && product_o === '0, "R1 reset mid-run", product_o, '0);
    rst_n = 1'b1;
    repeat (N * 3) @(negedge clk);
    check(done_o === 1'b0 && product_o === '0, "R1 idle after reset", product_o, '0);
    run_mul(8'hC3, 8'h9D, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule